// File: doc/BRIEF.md
# Select-Pin Clock Bank Divider

This block turns one source clock into three banks of synchronous clocks (a CPU bank, a PCI bank and an APIC bank), each with its own output enable. Three select pins choose the operating mode. The modes are high impedance, reserved, test and normal. A strap input picks one of two APIC variants. In the first, the APIC bank is a divided copy of the PCI clock. In the second, the APIC bank is left to another source except in test mode. The CPU bank always runs at half the source rate. The PCI bank runs at one half or one third of the CPU rate, depending on the 100-MHz select pin.

The select pins and the strap are registered once and decoded into a configuration. A small state machine controls the dividers. After reset it starts in `ST_BOOT` and always moves to `ST_QUIET` on the next cycle. `ST_QUIET` loads the new configuration, clears every divider and holds all clock levels low for `QUIET_CYCLES` cycles, then moves to `ST_RUN`. In `ST_RUN` the state machine compares the decoded pin state with the loaded configuration. On any difference it returns to `ST_QUIET`, so the CPU, PCI and APIC banks always restart from a common rising edge.

Top module: `seldiv_top`

## Requirements
- R1: With select code 000 on {sel100, sel1, sel0}, every clock output is low and all three enables are deasserted.
- R2: With select code 100 (test mode), the CPU bank runs at the source clock divided by 2 and the PCI bank at the source clock divided by 6.
- R3: In test mode with strap 1, the APIC bank runs at the source clock divided by 12. With strap 0, the APIC bank carries the source clock itself. The APIC enable is asserted in both cases.
- R4: With select code x11 (normal mode), the CPU bank runs at the source divided by 2. The PCI bank runs at the source divided by 4 when sel100 is 0 (ratio 2) and divided by 6 when sel100 is 1 (ratio 3).
- R5: In normal mode with strap 1, the APIC bank runs at half the PCI rate with its enable asserted. With strap 0, the APIC bank is low and its enable is deasserted.
- R6: In the reserved codes 001, 010, 101 and 110, the CPU and PCI banks are low with their enables asserted. The APIC bank is low, and its enable equals the strap.
- R7: Every rising edge of the PCI bank coincides with a rising edge of the CPU bank. Every rising edge of a divided APIC bank coincides with a rising edge of the PCI bank.
- R8: The PCI bank has a 50 % duty cycle: it is high for exactly `ratio` source cycles in each period. The CPU and divided APIC banks are also high for half of their periods.
- R9: A change of the decoded configuration clears all dividers together. All levels are then held low for at least two cycles, after which the CPU, PCI and APIC banks rise on the same source edge.
- R10: While reset is asserted, and on the first cycle after it is released, all clock outputs and enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock (test clock in test mode) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel100_i | input | 1 | Frequency select, chooses PCI ratio 3 when high |
| sel1_i | input | 1 | Mode select, upper bit |
| sel0_i | input | 1 | Mode select, lower bit |
| apic_pci_i | input | 1 | Strap: 1 derives APIC from PCI, 0 leaves APIC to another source |
| cpu_clk_o | output | CPU_N | CPU clock bank |
| cpu_oe_o | output | 1 | CPU bank enable |
| pci_clk_o | output | PCI_N | PCI clock bank |
| pci_oe_o | output | 1 | PCI bank enable |
| apic_clk_o | output | APIC_N | APIC clock bank |
| apic_oe_o | output | 1 | APIC bank enable |

## Verification
The hardest behaviour to observe from the ports is the common restart after a select change. In steady running, the CPU bank is never low for two samples in a row. The bench therefore switches directly between two running configurations and scans the following samples for the first CPU rise that follows at least two low samples. At that sample, the PCI and APIC banks must also be high. The test-mode pass-through is sampled both in the high and in the low half of the source clock, because a registered level alone cannot show it.

// File: rtl/seldiv_pkg.sv
package seldiv_pkg;

    typedef enum logic [1:0] {
        MODE_HIZ  = 2'd0,
        MODE_RSVD = 2'd1,
        MODE_TEST = 2'd2,
        MODE_RUN  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_QUIET = 2'd1,
        ST_RUN   = 2'd2
    } ctl_state_e;

    typedef struct packed {
        mode_e mode;
        logic  ratio_hi;
        logic  apic_pci;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{mode: MODE_HIZ, ratio_hi: 1'b0, apic_pci: 1'b0};

endpackage

// File: rtl/seldiv_decode.sv
module seldiv_decode
    import seldiv_pkg::*;
(
    input  logic [3:0] pins_i,
    output cfg_t       cfg_o
);

    logic [2:0] code_w;
    assign code_w = pins_i[3:1];

    always_comb begin
        cfg_o.ratio_hi = pins_i[3];
        cfg_o.apic_pci = pins_i[0];
        unique case (code_w)
            3'b000:         cfg_o.mode = MODE_HIZ;
            3'b100:         cfg_o.mode = MODE_TEST;
            3'b011, 3'b111: cfg_o.mode = MODE_RUN;
            default:        cfg_o.mode = MODE_RSVD;
        endcase
    end

endmodule

// File: rtl/seldiv_ctrl.sv
module seldiv_ctrl
    import seldiv_pkg::*;
#(
    parameter int QUIET_CYCLES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [3:0] pins_i,
    output logic [3:0] pins_q_o,
    input  cfg_t       cfg_nx_i,
    output cfg_t       cfg_o,
    output logic       clr_o
);

    localparam int QW = $clog2(QUIET_CYCLES + 1);
    localparam logic [QW-1:0] Q_LAST = QW'(QUIET_CYCLES - 1);

    ctl_state_e state_q, state_nx;
    cfg_t       cfg_q;
    logic [QW-1:0] quiet_cnt_q;
    logic [3:0] pins_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_BOOT;
        else         state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_BOOT:  state_nx = ST_QUIET;
            ST_QUIET: if (quiet_cnt_q == Q_LAST) state_nx = ST_RUN;
            ST_RUN:   if (cfg_nx_i != cfg_q) state_nx = ST_QUIET;
            default:  state_nx = ST_BOOT;
        endcase
    end

    // outputs
    always_comb begin
        clr_o    = (state_q != ST_RUN);
        cfg_o    = cfg_q;
        pins_q_o = pins_q;
    end

    // datapath: pin capture, configuration load, quiet window count
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pins_q      <= '0;
            cfg_q       <= CFG_RESET;
            quiet_cnt_q <= '0;
        end else begin
            pins_q <= pins_i;
            if (state_nx == ST_QUIET && state_q != ST_QUIET) begin
                cfg_q       <= cfg_nx_i;
                quiet_cnt_q <= '0;
            end else if (state_q == ST_QUIET) begin
                quiet_cnt_q <= quiet_cnt_q + 1'b1;
            end
        end
    end

    AST_REALIGN_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && cfg_nx_i != cfg_q) |=> (state_q == ST_QUIET && clr_o)); // R9

    AST_CFG_HELD_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && $past(state_q) == ST_RUN) |-> $stable(cfg_q)); // R9

endmodule

// File: rtl/seldiv_phase.sv
module seldiv_phase
    import seldiv_pkg::*;
#(
    parameter int RATIO_LO     = 2,
    parameter int RATIO_HI     = 3,
    parameter int APIC_PER_PCI = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  cfg_t cfg_i,
    output logic cpu_lv_o,
    output logic pci_lv_o,
    output logic apic_lv_o
);

    localparam int CW = $clog2(2 * RATIO_HI);
    localparam int AW = $clog2(APIC_PER_PCI);
    localparam logic [CW-1:0] LAST_LO  = CW'(2 * RATIO_LO - 1);
    localparam logic [CW-1:0] LAST_HI  = CW'(2 * RATIO_HI - 1);
    localparam logic [AW-1:0] A_LAST   = AW'(APIC_PER_PCI - 1);
    localparam logic [AW-1:0] A_HALF   = AW'(APIC_PER_PCI / 2);

    logic [CW-1:0] cnt_q;
    logic [AW-1:0] acnt_q;
    logic          active_q;
    logic          run_w;
    logic          en_w;
    logic [CW-1:0] ratio_w;
    logic [CW-1:0] last_w;

    assign run_w   = (cfg_i.mode == MODE_TEST) || (cfg_i.mode == MODE_RUN);
    assign ratio_w = cfg_i.ratio_hi ? CW'(RATIO_HI) : CW'(RATIO_LO);
    assign last_w  = cfg_i.ratio_hi ? LAST_HI : LAST_LO;
    assign en_w    = active_q && !clr_i && run_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q    <= '0;
            acnt_q   <= '0;
            active_q <= 1'b0;
        end else if (clr_i || !run_w) begin
            cnt_q    <= '0;
            acnt_q   <= '0;
            active_q <= 1'b0;
        end else begin
            active_q <= 1'b1;
            if (active_q) begin
                if (cnt_q >= last_w) begin
                    cnt_q  <= '0;
                    acnt_q <= (acnt_q == A_LAST) ? '0 : acnt_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        cpu_lv_o  = en_w && !cnt_q[0];
        pci_lv_o  = en_w && (cnt_q < ratio_w);
        apic_lv_o = en_w && (acnt_q < A_HALF);
    end

    AST_CPU_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_w && $past(en_w)) |-> (cpu_lv_o != $past(cpu_lv_o))); // R2

    AST_PCI_LAGS_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pci_lv_o) |-> $rose(cpu_lv_o)); // R7

    AST_APIC_LAGS_PCI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(apic_lv_o) |-> $rose(pci_lv_o)); // R7

endmodule

// File: rtl/seldiv_drive.sv
module seldiv_drive
    import seldiv_pkg::*;
#(
    parameter int CPU_N  = 4,
    parameter int PCI_N  = 7,
    parameter int APIC_N = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  cfg_t              cfg_i,
    input  logic              cpu_lv_i,
    input  logic              pci_lv_i,
    input  logic              apic_lv_i,
    output logic [CPU_N-1:0]  cpu_clk_o,
    output logic              cpu_oe_o,
    output logic [PCI_N-1:0]  pci_clk_o,
    output logic              pci_oe_o,
    output logic [APIC_N-1:0] apic_clk_o,
    output logic              apic_oe_o
);

    logic cpu_q, pci_q, apic_q, pass_q;
    logic cpu_oe_q, pci_oe_q, apic_oe_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cpu_q     <= 1'b0;
            pci_q     <= 1'b0;
            apic_q    <= 1'b0;
            pass_q    <= 1'b0;
            cpu_oe_q  <= 1'b0;
            pci_oe_q  <= 1'b0;
            apic_oe_q <= 1'b0;
        end else begin
            cpu_q     <= cpu_lv_i;
            pci_q     <= pci_lv_i;
            apic_q    <= cfg_i.apic_pci && apic_lv_i;
            pass_q    <= (cfg_i.mode == MODE_TEST) && !cfg_i.apic_pci;
            cpu_oe_q  <= (cfg_i.mode != MODE_HIZ);
            pci_oe_q  <= (cfg_i.mode != MODE_HIZ);
            apic_oe_q <= (cfg_i.mode == MODE_TEST) ||
                         ((cfg_i.mode != MODE_HIZ) && cfg_i.apic_pci);
        end
    end

    assign cpu_oe_o  = cpu_oe_q;
    assign pci_oe_o  = pci_oe_q;
    assign apic_oe_o = apic_oe_q;

    for (genvar gi = 0; gi < CPU_N; gi++) begin : g_cpu
        assign cpu_clk_o[gi] = cpu_q;
    end
    for (genvar gi = 0; gi < PCI_N; gi++) begin : g_pci
        assign pci_clk_o[gi] = pci_q;
    end
    for (genvar gi = 0; gi < APIC_N; gi++) begin : g_apic
        assign apic_clk_o[gi] = pass_q ? clk_i : apic_q;
    end

    AST_HIZ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i.mode == MODE_HIZ) |=> (!cpu_oe_o && !pci_oe_o && !apic_oe_o &&
                                     cpu_clk_o == '0 && pci_clk_o == '0 && !apic_q && !pass_q)); // R1

    AST_RSVD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i.mode == MODE_RSVD) |=> (cpu_clk_o == '0 && pci_clk_o == '0 && !apic_q &&
                                      cpu_oe_o && pci_oe_o)); // R6

    AST_APIC_OFF_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i.mode == MODE_RUN && !cfg_i.apic_pci) |=> (!apic_oe_o && !apic_q)); // R5

endmodule

// File: rtl/seldiv_top.sv
module seldiv_top
    import seldiv_pkg::*;
#(
    parameter int CPU_N        = 4,
    parameter int PCI_N        = 7,
    parameter int APIC_N       = 2,
    parameter int RATIO_LO     = 2,
    parameter int RATIO_HI     = 3,
    parameter int APIC_PER_PCI = 2,
    parameter int QUIET_CYCLES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel100_i,
    input  logic              sel1_i,
    input  logic              sel0_i,
    input  logic              apic_pci_i,
    output logic [CPU_N-1:0]  cpu_clk_o,
    output logic              cpu_oe_o,
    output logic [PCI_N-1:0]  pci_clk_o,
    output logic              pci_oe_o,
    output logic [APIC_N-1:0] apic_clk_o,
    output logic              apic_oe_o
);

    logic [3:0] pins_q;
    cfg_t       cfg_nx;
    cfg_t       cfg;
    logic       clr;
    logic       cpu_lv, pci_lv, apic_lv;

    seldiv_ctrl #(.QUIET_CYCLES(QUIET_CYCLES)) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pins_i   ({sel100_i, sel1_i, sel0_i, apic_pci_i}),
        .pins_q_o (pins_q),
        .cfg_nx_i (cfg_nx),
        .cfg_o    (cfg),
        .clr_o    (clr)
    );

    seldiv_decode u_decode (
        .pins_i (pins_q),
        .cfg_o  (cfg_nx)
    );

    seldiv_phase #(
        .RATIO_LO     (RATIO_LO),
        .RATIO_HI     (RATIO_HI),
        .APIC_PER_PCI (APIC_PER_PCI)
    ) u_phase (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (clr),
        .cfg_i     (cfg),
        .cpu_lv_o  (cpu_lv),
        .pci_lv_o  (pci_lv),
        .apic_lv_o (apic_lv)
    );

    seldiv_drive #(
        .CPU_N  (CPU_N),
        .PCI_N  (PCI_N),
        .APIC_N (APIC_N)
    ) u_drive (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_i      (cfg),
        .cpu_lv_i   (cpu_lv),
        .pci_lv_i   (pci_lv),
        .apic_lv_i  (apic_lv),
        .cpu_clk_o  (cpu_clk_o),
        .cpu_oe_o   (cpu_oe_o),
        .pci_clk_o  (pci_clk_o),
        .pci_oe_o   (pci_oe_o),
        .apic_clk_o (apic_clk_o),
        .apic_oe_o  (apic_oe_o)
    );

endmodule

// File: tb/seldiv_top_test.sv
module seldiv_top_test;

    localparam int CPU_N  = 4;
    localparam int PCI_N  = 7;
    localparam int APIC_N = 2;
    localparam int WIN    = 24;

    typedef struct packed {
        logic [2:0] sel;
        logic       strap;
        logic       cpu_oe;
        logic       pci_oe;
        logic       apic_oe;
        logic [4:0] cpu_r;
        logic [4:0] pci_r;
        logic [4:0] apic_r;
        logic [4:0] cpu_h;
        logic [4:0] pci_h;
        logic [4:0] apic_h;
        logic       pass;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  5'd0, 5'd0, 5'd0,  5'd0,  5'd0,  1'b0},
        '{3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd0, 5'd0, 5'd0,  5'd0,  5'd0,  1'b0},
        '{3'b100, 1'b1, 1'b1, 1'b1, 1'b1, 5'd12, 5'd4, 5'd2, 5'd12, 5'd12, 5'd12, 1'b0},
        '{3'b100, 1'b0, 1'b1, 1'b1, 1'b1, 5'd12, 5'd4, 5'd0, 5'd12, 5'd12, 5'd24, 1'b1},
        '{3'b011, 1'b1, 1'b1, 1'b1, 1'b1, 5'd12, 5'd6, 5'd3, 5'd12, 5'd12, 5'd12, 1'b0},
        '{3'b111, 1'b1, 1'b1, 1'b1, 1'b1, 5'd12, 5'd4, 5'd2, 5'd12, 5'd12, 5'd12, 1'b0},
        '{3'b011, 1'b0, 1'b1, 1'b1, 1'b0, 5'd12, 5'd6, 5'd0, 5'd12, 5'd12, 5'd0,  1'b0},
        '{3'b111, 1'b0, 1'b1, 1'b1, 1'b0, 5'd12, 5'd4, 5'd0, 5'd12, 5'd12, 5'd0,  1'b0},
        '{3'b001, 1'b1, 1'b1, 1'b1, 1'b1, 5'd0,  5'd0, 5'd0, 5'd0,  5'd0,  5'd0,  1'b0},
        '{3'b010, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0,  5'd0, 5'd0, 5'd0,  5'd0,  5'd0,  1'b0},
        '{3'b101, 1'b1, 1'b1, 1'b1, 1'b1, 5'd0,  5'd0, 5'd0, 5'd0,  5'd0,  5'd0,  1'b0},
        '{3'b110, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0,  5'd0, 5'd0, 5'd0,  5'd0,  5'd0,  1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel100 = 1'b0, sel1 = 1'b0, sel0 = 1'b0, strap = 1'b0;
    logic [CPU_N-1:0]  cpu_clk;
    logic [PCI_N-1:0]  pci_clk;
    logic [APIC_N-1:0] apic_clk;
    logic cpu_oe, pci_oe, apic_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seldiv_top uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sel100_i   (sel100),
        .sel1_i     (sel1),
        .sel0_i     (sel0),
        .apic_pci_i (strap),
        .cpu_clk_o  (cpu_clk),
        .cpu_oe_o   (cpu_oe),
        .pci_clk_o  (pci_clk),
        .pci_oe_o   (pci_oe),
        .apic_clk_o (apic_clk),
        .apic_oe_o  (apic_oe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string mode_req(input logic [2:0] s);
        if (s == 3'b000) return "R1";
        if (s == 3'b100) return "R2";
        if (s[1:0] == 2'b11) return "R4";
        return "R6";
    endfunction

    function automatic string apic_req(input logic [2:0] s);
        if (s == 3'b000) return "R1";
        if (s == 3'b100) return "R3";
        if (s[1:0] == 2'b11) return "R5";
        return "R6";
    endfunction

    task automatic apply(input logic [2:0] s, input logic st);
        @(negedge clk);
        sel100 = s[2];
        sel1   = s[1];
        sel0   = s[0];
        strap  = st;
    endtask

    task automatic sample();
        @(posedge clk);
        #5;
    endtask

    task automatic measure(input vec_t v);
        int cr = 0, pr = 0, ar = 0, ch = 0, ph = 0, ah = 0;
        int bank_bad = 0, align_bad = 0, pass_bad = 0;
        logic pc, pp, pa;
        sample();
        pc = cpu_clk[0]; pp = pci_clk[0]; pa = apic_clk[0];
        for (int i = 0; i < WIN; i++) begin
            logic c, p, a;
            sample();
            c = cpu_clk[0]; p = pci_clk[0]; a = apic_clk[0];
            if (cpu_clk != {CPU_N{c}} || pci_clk != {PCI_N{p}} || apic_clk != {APIC_N{a}})
                bank_bad++;
            if (c && !pc) cr++;
            if (p && !pp) pr++;
            if (a && !pa) ar++;
            if (c) ch++;
            if (p) ph++;
            if (a) ah++;
            if (p && !pp && !(c && !pc)) align_bad++;
            if (!v.pass && a && !pa && !(p && !pp)) align_bad++;
            if (v.pass) begin
                #10;
                if (apic_clk[0] !== 1'b0) pass_bad++;
            end
            pc = c; pp = p; pa = a;
        end
        check(mode_req(v.sel), "cpu enable", int'(cpu_oe), int'(v.cpu_oe));
        check(mode_req(v.sel), "pci enable", int'(pci_oe), int'(v.pci_oe));
        check(apic_req(v.sel), "apic enable", int'(apic_oe), int'(v.apic_oe));
        check(mode_req(v.sel), "cpu rises", cr, int'(v.cpu_r));
        check(mode_req(v.sel), "pci rises", pr, int'(v.pci_r));
        check(apic_req(v.sel), "apic rises", ar, int'(v.apic_r));
        check("R8", "cpu high samples", ch, int'(v.cpu_h));
        check("R8", "pci high samples", ph, int'(v.pci_h));
        check(apic_req(v.sel), "apic high samples", ah, int'(v.apic_h));
        check("R7", "unaligned rises", align_bad, 0);
        check(mode_req(v.sel), "bank members differ", bank_bad, 0);
        if (v.pass) check("R3", "pass-through low half", pass_bad, 0);
    endtask

    task automatic realign(input logic [2:0] s_from, input logic [2:0] s_to);
        logic [15:0] c, p, a;
        int hit = -1;
        apply(s_from, 1'b1);
        repeat (12) sample();
        apply(s_to, 1'b1);
        for (int i = 0; i < 16; i++) begin
            sample();
            c[i] = cpu_clk[0]; p[i] = pci_clk[0]; a[i] = apic_clk[0];
        end
        for (int i = 2; i < 16; i++) begin
            if (hit < 0 && c[i] && !c[i-1] && !c[i-2]) hit = i;
        end
        check("R9", "restart edge found", int'(hit >= 0), 1);
        if (hit >= 0) begin
            check("R9", "pci rises with restart", int'(p[hit] && !p[hit-1]), 1);
            check("R9", "apic rises with restart", int'(a[hit] && !a[hit-1]), 1);
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state with a running code applied
        sel100 = 1'b0; sel1 = 1'b1; sel0 = 1'b1; strap = 1'b1;
        repeat (3) sample();
        check("R10", "outputs in reset", int'({cpu_clk, pci_clk, apic_clk} != '0), 0);
        check("R10", "enables in reset", int'({cpu_oe, pci_oe, apic_oe}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        sample();
        check("R10", "outputs first cycle", int'({cpu_clk, pci_clk, apic_clk} != '0), 0);
        check("R10", "enables first cycle", int'({cpu_oe, pci_oe, apic_oe}), 0);

        for (int k = 0; k < 12; k++) begin
            apply(VECS[k].sel, VECS[k].strap);
            repeat (10) sample();
            measure(VECS[k]);
        end

        // R9: restart alignment across running configurations
        realign(3'b011, 3'b111);
        realign(3'b111, 3'b011);
        realign(3'b111, 3'b100);

        // R10: reset during running
        apply(3'b011, 1'b1);
        repeat (10) sample();
        @(negedge clk);
        rst_n = 1'b0;
        sample();
        check("R10", "outputs mid-run reset", int'({cpu_clk, pci_clk, apic_clk} != '0), 0);
        check("R10", "enables mid-run reset", int'({cpu_oe, pci_oe, apic_oe}), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule